// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with One-Shot Subtraction Correction

This block divides a real-time-clock count source into sixteenths of a second and into whole seconds. An 11-bit lower counter steps once for every count-source cycle, which the block sees as a clock cycle with `src_en` high. When the lower counter rolls over from 7FFh to 000h, the block raises a 1/16-second tick and advances a 4-bit upper counter. When the upper counter rolls over from Fh to 0h, the block also raises a one-second tick.

Software can slow the clock by a small, exact amount. It writes a 6-bit amount M and strobes a subtract request. After a fixed delay of three count-source steps, the lower counter runs through the values 001h..M a second time inside one 1/16-second period. That period then lasts 2048+M steps. The count source is never gated, so the adjustment comes only from the re-counted values.

The extension lands in the period in progress if the counter has not yet gone past M when the delay ends. Otherwise it lands in the next period. A busy flag covers the whole span from acceptance to completion.

Top module: `rtc_tick_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following all read 0 after that edge: `lo_cnt`, `hi_cnt`, `tick_16th`, `tick_sec` and `corr_busy`.
- R2: The lower counter advances by one on each clock edge with `src_en` high and holds its value when `src_en` is low. Without correction, consecutive `tick_16th` pulses are 2048 steps apart.
- R3: `tick_16th` is a one-cycle pulse. It is high in the cycle in which `lo_cnt` first shows 000h after a 7FFh-to-000h step. `hi_cnt` advances by one on that same edge.
- R4: `tick_sec` is high only together with a `tick_16th` pulse whose edge took `hi_cnt` from Fh to 0h. It therefore occurs once every 16 `tick_16th` pulses.
- R5: A request is accepted at a clock edge where `sub_req` is 1, `auto_en` is 0 and `corr_busy` is 0. `corr_busy` reads 1 from the next cycle until the correction finishes.
- R6: A request made while `auto_en` is 1 is ignored. `corr_busy` stays 0 and no period is lengthened.
- R7: A request made while `corr_busy` is 1 is ignored. Its amount never adds to the period length.
- R8: An accepted correction with M>0 lengthens exactly one 1/16-second period to 2048+M steps. It does this by sending the counter from M back to 001h once. The neighbouring periods stay at 2048 steps.
- R9: Let the acceptance edge be a counting step. The block then waits for three further steps. If the lower counter holds a value of at most M after those three steps, the extension lands in the current period. Otherwise it lands in the following period.
- R10: With M=0, no extra steps are added. `corr_busy` clears on the first clock edge after the three delay steps.
- R11: M is captured at acceptance. Changing `corr_amt` afterwards has no effect on the correction in progress.
- R12: For M>0, `corr_busy` clears on the second edge that leaves M, that is, the edge on which the lower counter goes from M to M+1. After that edge, `lo_cnt` shows M+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_en | input | 1 | One count-source cycle occurs in this clock cycle |
| corr_amt | input | 6 | Subtraction amount M, sampled on acceptance |
| sub_req | input | 1 | Subtract request strobe |
| auto_en | input | 1 | Automatic correction selected; blocks software requests |
| lo_cnt | output | 11 | Lower prescaler counter |
| hi_cnt | output | 4 | Sixteenth-of-a-second counter |
| tick_16th | output | 1 | One-cycle pulse at each lower-counter rollover |
| tick_sec | output | 1 | One-cycle pulse at each upper-counter rollover |
| corr_busy | output | 1 | A correction is pending or in progress |

## Verification
Two functions can fall on the same counting step. One is the end of the three-step delay, when the correction becomes armed. The other is the step on which the lower counter leaves M, where the block decides between the current period and the next.

Table rows issue the request exactly four values below M and then three values below M. In the first case the arming completes just before the counter leaves M. In the second it completes just after.

Each row is judged by measuring the lengths of two consecutive periods at the tick output and by recording the counter value at which the busy flag falls. The first case must extend the current period, and the second must extend the next one.

// File: rtl/rtc_div_pkg.sv
// Shared types for the RTC prescaler.
// Assumes: nothing beyond standard SystemVerilog.
package rtc_div_pkg;

    // Phases of the one-shot subtraction correction.
    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,  // no correction pending
        CS_SYNC   = 2'd1,  // waiting out the fixed step delay
        CS_ARMED  = 2'd2,  // watching for the counter to leave M
        CS_REPEAT = 2'd3   // second pass over 1..M
    } corr_state_e;

endpackage

// File: rtl/rtc_lo_counter.sv
// Lower prescaler counter.
// Steps once per count-source cycle, wraps from all-ones to zero and flags the
// wrap. A restart request sends it to 1 instead of incrementing.
// Assumes: restart never coincides with the all-ones value.
module rtc_lo_counter #(
    parameter int LO_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            restart,
    output logic [LO_W-1:0] lo_val,
    output logic            wrap,
    output logic            tick
);

    localparam logic [LO_W-1:0] LO_MAX = {LO_W{1'b1}};
    localparam logic [LO_W-1:0] LO_ONE = LO_W'(1);

    logic [LO_W-1:0] cnt_q;
    logic            tick_q;

    // Rollover strobe for the upper counter, valid on the stepping edge.
    always_comb wrap = step && (cnt_q == LO_MAX);

    // Counter advance, with the restart path used by the correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (step) begin
                cnt_q <= restart ? LO_ONE : cnt_q + LO_ONE;
            end
        end
    end

    assign lo_val = cnt_q;
    assign tick   = tick_q;

endmodule

// File: rtl/rtc_hi_counter.sv
// Upper counter of sixteenths of a second.
// Advances on each lower-counter wrap and emits a one-cycle pulse on its own
// rollover.
// Assumes: wrap is a single-cycle strobe.
module rtc_hi_counter #(
    parameter int HI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap,
    output logic [HI_W-1:0] hi_val,
    output logic            sec_tick
);

    localparam logic [HI_W-1:0] HI_MAX = {HI_W{1'b1}};

    logic [HI_W-1:0] cnt_q;
    logic            sec_q;

    // Count sixteenths and register the whole-second rollover pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sec_q <= 1'b0;
        end else begin
            sec_q <= wrap && (cnt_q == HI_MAX);
            if (wrap) begin
                cnt_q <= cnt_q + HI_W'(1);
            end
        end
    end

    assign hi_val   = cnt_q;
    assign sec_tick = sec_q;

endmodule

// File: rtl/rtc_sub_ctrl.sv
// Subtraction-correction sequencer.
// Accepts a request, counts a fixed number of source steps, and then makes
// the lower counter re-count 1..M once by restarting it at the step that
// leaves M.
// Assumes: LO_W > AMT_W, so M is always below the lower counter's rollover.
module rtc_sub_ctrl
    import rtc_div_pkg::*;
#(
    parameter int LO_W       = 11,
    parameter int AMT_W      = 6,
    parameter int SYNC_STEPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             sub_req,
    input  logic             auto_en,
    input  logic [AMT_W-1:0] corr_amt,
    input  logic [LO_W-1:0]  lo_val,
    output logic             restart,
    output logic             busy
);

    localparam int SYNC_W = $clog2(SYNC_STEPS + 1);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_STEPS - 1);

    corr_state_e      state_q;
    logic [AMT_W-1:0] amt_q;
    logic [SYNC_W-1:0] sync_q;
    logic             hit;
    logic             amt_zero;

    // Compare the lower counter with the latched amount.
    always_comb begin
        hit      = (lo_val == {{(LO_W-AMT_W){1'b0}}, amt_q});
        amt_zero = (amt_q == '0);
        restart  = step && (state_q == CS_ARMED) && hit && !amt_zero;
        busy     = (state_q != CS_IDLE);
    end

    // Correction sequencing: accept, delay, restart once, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            amt_q   <= '0;
            sync_q  <= '0;
        end else begin
            unique case (state_q)
                CS_IDLE: begin
                    if (sub_req && !auto_en) begin
                        amt_q   <= corr_amt;
                        sync_q  <= '0;
                        state_q <= CS_SYNC;
                    end
                end
                CS_SYNC: begin
                    if (step) begin
                        sync_q <= sync_q + SYNC_W'(1);
                        if (sync_q == SYNC_LAST) begin
                            state_q <= CS_ARMED;
                        end
                    end
                end
                CS_ARMED: begin
                    if (amt_zero) begin
                        state_q <= CS_IDLE;
                    end else if (step && hit) begin
                        state_q <= CS_REPEAT;
                    end
                end
                CS_REPEAT: begin
                    if (step && hit) begin
                        state_q <= CS_IDLE;
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtc_tick_divider.sv
// RTC prescaler top.
// Divides the count source into 1/16-second and one-second ticks and applies
// one-shot subtraction corrections on request.
// Assumes: src_en marks one count-source cycle per clock; inputs are
// synchronous to clk.
module rtc_tick_divider #(
    parameter int LO_W       = 11,
    parameter int HI_W       = 4,
    parameter int AMT_W      = 6,
    parameter int SYNC_STEPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic [AMT_W-1:0] corr_amt,
    input  logic             sub_req,
    input  logic             auto_en,
    output logic [LO_W-1:0]  lo_cnt,
    output logic [HI_W-1:0]  hi_cnt,
    output logic             tick_16th,
    output logic             tick_sec,
    output logic             corr_busy
);

    logic lo_wrap;
    logic lo_restart;

    rtc_lo_counter #(.LO_W(LO_W)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (src_en),
        .restart (lo_restart),
        .lo_val  (lo_cnt),
        .wrap    (lo_wrap),
        .tick    (tick_16th)
    );

    rtc_hi_counter #(.HI_W(HI_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (lo_wrap),
        .hi_val   (hi_cnt),
        .sec_tick (tick_sec)
    );

    rtc_sub_ctrl #(
        .LO_W       (LO_W),
        .AMT_W      (AMT_W),
        .SYNC_STEPS (SYNC_STEPS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (src_en),
        .sub_req  (sub_req),
        .auto_en  (auto_en),
        .corr_amt (corr_amt),
        .lo_val   (lo_cnt),
        .restart  (lo_restart),
        .busy     (corr_busy)
    );

endmodule

// File: rtl/rtc_tick_divider_chk.sv
// Port-level property checker for the RTC prescaler, bound to every instance.
// Assumes: synchronous active-low reset.
module rtc_tick_divider_chk #(
    parameter int LO_W = 11,
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            src_en,
    input logic            sub_req,
    input logic            auto_en,
    input logic [LO_W-1:0] lo_cnt,
    input logic [HI_W-1:0] hi_cnt,
    input logic            tick_16th,
    input logic            tick_sec,
    input logic            corr_busy
);

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en |=> $stable(lo_cnt));                                   // R2

    AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick_16th |-> (lo_cnt == '0));                                  // R3

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_16th |=> !tick_16th);                                      // R3

    AST_SEC_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |-> (tick_16th && hi_cnt == '0));                      // R4

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_busy && sub_req && !auto_en) |=> corr_busy);             // R5

    AST_AUTO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_busy && auto_en) |=> !corr_busy);                        // R6

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_busy && !sub_req) |=> !corr_busy);                       // R5

endmodule

bind rtc_tick_divider rtc_tick_divider_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_en    (src_en),
    .sub_req   (sub_req),
    .auto_en   (auto_en),
    .lo_cnt    (lo_cnt),
    .hi_cnt    (hi_cnt),
    .tick_16th (tick_16th),
    .tick_sec  (tick_sec),
    .corr_busy (corr_busy)
);

// File: tb/sim_rtc_tick_divider.sv
module sim_rtc_tick_divider;

    localparam int PERIOD = 2048;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_en;
    logic [5:0]  corr_amt;
    logic        sub_req;
    logic        auto_en;
    logic [10:0] lo_cnt;
    logic [3:0]  hi_cnt;
    logic        tick_16th;
    logic        tick_sec;
    logic        corr_busy;

    int checks = 0;
    int fails  = 0;
    int fall_lo = -1;
    logic prev_busy = 1'b0;

    always #4 clk = ~clk;

    rtc_tick_divider u0 (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .corr_amt(corr_amt),
        .sub_req(sub_req), .auto_en(auto_en), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
        .tick_16th(tick_16th), .tick_sec(tick_sec), .corr_busy(corr_busy)
    );

    // Row layout: {extension lands in current period, M, request position}.
    localparam int NVEC = 7;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 6'd20, 11'd5},
        {1'b1, 6'd20, 11'd16},
        {1'b0, 6'd20, 11'd17},
        {1'b1, 6'd63, 11'd0},
        {1'b0, 6'd1,  11'd100},
        {1'b0, 6'd0,  11'd3},
        {1'b0, 6'd40, 11'd1000}
    };

    // Record the lower-counter value seen when the busy flag falls.
    always @(negedge clk) begin
        if (prev_busy && !corr_busy) fall_lo = int'(lo_cnt);
        prev_busy = corr_busy;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic sync_tick();
        @(negedge clk);
        while (!tick_16th) @(negedge clk);
    endtask

    // Measure steps to the next tick; issue requests at lower values s1, s2 (-1 = none).
    task automatic measure(input int s1, input logic [5:0] m1,
                           input int s2, input logic [5:0] m2, output int len);
        bit sent1 = 0;
        bit sent2 = 0;
        len = 0;
        forever begin
            if (!sent1 && s1 >= 0 && int'(lo_cnt) == s1) begin
                sub_req = 1'b1; corr_amt = m1; sent1 = 1;
            end else if (!sent2 && s2 >= 0 && int'(lo_cnt) == s2) begin
                sub_req = 1'b1; corr_amt = m2; sent2 = 1;
            end else begin
                sub_req = 1'b0; corr_amt = 6'd63;  // R11: amount changes after acceptance
            end
            @(negedge clk);
            len++;
            if (tick_16th) break;
        end
        sub_req = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int a, b, nt, m, s;
        bit cur;
        rst_n = 1'b0; src_en = 1'b1; corr_amt = '0; sub_req = 1'b0; auto_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 lo", int'(lo_cnt), 0);
        chk("R1 hi", int'(hi_cnt), 0);
        chk("R1 ticks/busy", int'({tick_16th, tick_sec, corr_busy}), 0);
        rst_n = 1'b1;

        // Table walk: R8, R9, R10, R11, R12.
        for (int i = 0; i < NVEC; i++) begin
            cur = VEC[i][17];
            m   = int'(VEC[i][16:11]);
            s   = int'(VEC[i][10:0]);
            sync_tick();
            fall_lo = -1;
            measure(s, 6'(m), -1, 6'd0, a);
            measure(-1, 6'd0, -1, 6'd0, b);
            if (m == 0) begin
                chk("R10 period A", a, PERIOD);
                chk("R10 period B", b, PERIOD);
                chk("R10 busy fall", fall_lo, s + 5);
            end else begin
                chk("R9 period A", a, cur ? PERIOD + m : PERIOD);
                chk("R8 period B", b, cur ? PERIOD : PERIOD + m);
                chk("R12 busy fall", fall_lo, m + 1);
            end
        end

        // R7: second request during busy ignored.
        sync_tick();
        measure(5, 6'd10, 6, 6'd30, a);
        measure(-1, 6'd0, -1, 6'd0, b);
        chk("R7 period A", a, PERIOD + 10);
        chk("R7 period B", b, PERIOD);

        // R6: automatic mode blocks software request.
        auto_en = 1'b1;
        sync_tick();
        measure(2, 6'd20, -1, 6'd0, a);
        chk("R6 busy", int'(corr_busy), 0);
        measure(-1, 6'd0, -1, 6'd0, b);
        chk("R6 period A", a, PERIOD);
        chk("R6 period B", b, PERIOD);
        auto_en = 1'b0;

        // R5: busy seen the cycle after acceptance.
        sync_tick();
        sub_req = 1'b1; corr_amt = 6'd30;
        @(negedge clk);
        sub_req = 1'b0;
        chk("R5 busy after accept", int'(corr_busy), 1);
        measure(-1, 6'd0, -1, 6'd0, a);
        chk("R5/R8 period", a, PERIOD + 30 - 1);

        // R2: counter holds with no source step.
        @(negedge clk);
        a = int'(lo_cnt);
        src_en = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 hold", int'(lo_cnt), a);
        src_en = 1'b1;
        @(negedge clk);
        chk("R2 resume", int'(lo_cnt), (a + 1) % PERIOD);

        // R3/R4: upper counter and one-second tick.
        sync_tick();
        a = int'(hi_cnt);
        sync_tick();
        chk("R3 hi step", int'(hi_cnt), (a + 1) % 16);
        while (!tick_sec) @(negedge clk);
        chk("R4 hi at second", int'(hi_cnt), 0);
        chk("R4 tick together", int'(tick_16th), 1);
        nt = 0;
        do begin
            @(negedge clk);
            if (tick_16th) nt++;
        end while (!tick_sec);
        chk("R4 ticks per second", nt, 16);

        // R1: reset mid-run.
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 lo mid-run", int'(lo_cnt), 0);
        chk("R1 hi mid-run", int'(hi_cnt), 0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule